// File: doc/BRIEF.md
# Serial LSTM Layer Engine

This block evaluates one recurrent LSTM layer over a window of input vectors, one multiply per operand stream per clock. It holds the input window, the kernel weights, the recurrent weights, the biases, the cell state and the produced hidden outputs in on-chip arrays. After a start pulse it walks every timestep and every hidden unit. For each unit it forms the four gate pre-activations in a fixed order (input, forget, candidate, output). Two multiply-accumulate lanes run side by side: one multiplies input features by kernel weights, the other multiplies the previous hidden vector by recurrent weights. A combining stage adds both partial sums to the bias.

All values are signed 8-bit with 4 fractional bits (1.0 = 16). Gates use a piecewise-linear sigmoid. The candidate and the cell-to-output path use a clamping tanh. Each hidden result goes into an output array that a downstream consumer reads combinationally. The arrays are filled through a simple write port while the engine is idle. A one-cycle done pulse marks the end of the window.

Top module: `lstm_seq_engine`

## Requirements
- R1: After reset, busy and done are both 0.
- R2: Gate g (0 input, 1 forget, 2 candidate, 3 output) of unit u at step t has pre-activation z = sat8((sum_k x[t*FEAT+k]*K[(g*HID+u)*FEAT+k] + sum_j hprev[j]*R[(g*HID+u)*HID+j] + B[g*HID+u]*16) >>> 4). Here sat8 clamps to [-128,127] and the sum uses 24-bit accumulators.
- R3: Gates 0, 1 and 3 apply a hard sigmoid: 0 for z < -40, 16 for z > 40, and otherwise ((13*z+32) >>> 6) + 8.
- R4: The candidate gate applies a hard tanh: it clamps z to [-16,16].
- R5: The new cell is c = sat8((f*c_prev + i*g) >>> 4). The hidden output is h = (o*hardtanh(c)) >>> 4.
- R6: Cell and hidden state are zero at the start of every window, whatever the previous window left behind.
- R7: The hidden output of unit u at step t is stored at output address t*HID+u, and rd_data returns that entry in the same cycle as rd_addr.
- R8: done is high for exactly one cycle. It goes high STEPS*HID*(4*(KMAX+1)+1) clock edges after the edge that samples start, where KMAX = max(FEAT,HID).
- R9: While busy, start pulses and load writes are ignored. The timing and outputs of the running window are unchanged.
- R10: busy rises on the edge that samples start while idle, and it falls on the edge that raises done.
- R11: Loads use ld_sel 0 for input samples, 1 for kernel weights, 2 for recurrent weights and 3 for biases. Each is written at ld_addr on a clock edge with ld_en high while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a window when idle |
| busy | output | 1 | Window in progress |
| done | output | 1 | One-cycle end-of-window pulse |
| ld_en | input | 1 | Array write strobe |
| ld_sel | input | 2 | Target array: 0 input, 1 kernel, 2 recurrent, 3 bias |
| ld_addr | input | LAW | Write address within the selected array |
| ld_data | input | W | Signed Q4 write value |
| rd_addr | input | OAW | Output array read address |
| rd_data | output | W | Hidden value at rd_addr |

## Verification
The window length is fixed by the schedule. The bench counts clock edges from the start edge and samples done off-edge exactly one cycle before, at, and one cycle after the predicted edge. Hidden outputs are read only after done, with rd_addr applied and settled before rd_data is compared, because the read path has no register. Busy is sampled early in the run. Disturbing starts and kernel writes are applied mid-window, and the window must still finish on the predicted edge with the undisturbed results.

// File: rtl/lstm_pkg.sv
// Shared types for the serial LSTM engine.
// Assumes the gate order input, forget, candidate, output; the weight layout depends on it.
package lstm_pkg;
    typedef enum logic [1:0] {
        G_IN     = 2'd0,
        G_FORGET = 2'd1,
        G_CAND   = 2'd2,
        G_OUT    = 2'd3
    } gate_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ACC  = 2'd1,
        S_SUM  = 2'd2,
        S_UPD  = 2'd3
    } state_e;
endpackage

// File: rtl/lstm_mac.sv
// Signed multiply-accumulate lane.
// Assumes AW >= 2*PW; the product is sign-extended into the accumulator.
module lstm_mac #(
    parameter int PW = 8,
    parameter int AW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [PW-1:0] a,
    input  logic signed [PW-1:0] b,
    output logic signed [AW-1:0] acc
);
    logic signed [2*PW-1:0] prod;

    // full-precision product of the two operands
    assign prod = a * b;

    // accumulate when enabled, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (clr)    acc <= '0;
        else if (en)     acc <= acc + {{(AW-2*PW){prod[2*PW-1]}}, prod};
    end
endmodule

// File: rtl/lstm_act.sv
// Piecewise-linear activation: hard sigmoid (IS_SIG=1) or hard tanh (IS_SIG=0).
// Assumes FRAC=4 style Q format; the sigmoid slope is 13/64 with round-to-nearest.
module lstm_act #(
    parameter int W      = 8,
    parameter int FRAC   = 4,
    parameter bit IS_SIG = 1'b1
) (
    input  logic signed [W-1:0] z,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] ONE_S = W'(1 << FRAC);

    generate
        if (IS_SIG) begin : g_sig
            localparam logic signed [W-1:0]   KNEE_S = W'((5 << FRAC) / 2);
            localparam logic signed [W-1:0]   HALF_S = W'(1 << (FRAC - 1));
            localparam logic signed [W+7:0]   K_SLP  = (W+8)'(13);
            localparam logic signed [W+7:0]   K_RND  = (W+8)'(32);
            logic signed [W+7:0] zx;
            logic signed [W+7:0] lin;
            // scale by 0.2 with rounding
            assign zx  = {{8{z[W-1]}}, z};
            assign lin = (zx * K_SLP + K_RND) >>> 6;
            // clamp outside the knees, linear between
            always_comb begin
                if (z < -KNEE_S)      y = '0;
                else if (z > KNEE_S)  y = ONE_S;
                else                  y = $signed(lin[W-1:0]) + HALF_S;
            end
        end else begin : g_tanh
            // clamp to the unit interval
            always_comb begin
                if (z < -ONE_S)       y = -ONE_S;
                else if (z > ONE_S)   y = ONE_S;
                else                  y = z;
            end
        end
    endgenerate
endmodule

// File: rtl/lstm_cell_upd.sv
// Combinational cell and hidden state update from the four activated gates.
// Assumes gate values already in range (sigmoid 0..ONE, candidate -ONE..ONE).
module lstm_cell_upd #(
    parameter int W    = 8,
    parameter int FRAC = 4
) (
    input  logic signed [W-1:0] i_g,
    input  logic signed [W-1:0] f_g,
    input  logic signed [W-1:0] g_g,
    input  logic signed [W-1:0] o_g,
    input  logic signed [W-1:0] c_old,
    output logic signed [W-1:0] c_new,
    output logic signed [W-1:0] h_new
);
    localparam int PW = 2 * W + 1;
    localparam logic signed [PW-1:0] HI = PW'((1 << (W - 1)) - 1);
    localparam logic signed [PW-1:0] LO = PW'(-(1 << (W - 1)));

    logic signed [PW-1:0]    mix;
    logic signed [PW-1:0]    mix_sh;
    logic signed [W-1:0]     c_lim;
    logic signed [2*W-1:0]   hprod;

    // retained plus injected cell content, requantized with saturation
    always_comb begin
        mix    = PW'(f_g) * PW'(c_old) + PW'(i_g) * PW'(g_g);
        mix_sh = mix >>> FRAC;
        if (mix_sh > HI)       c_new = W'(HI);
        else if (mix_sh < LO)  c_new = W'(LO);
        else                   c_new = W'(mix_sh);
    end

    lstm_act #(.W(W), .FRAC(FRAC), .IS_SIG(1'b0)) u_tanh_c (.z(c_new), .y(c_lim));

    // output gate scales the clamped cell
    always_comb begin
        hprod = (2*W)'(o_g) * (2*W)'(c_lim);
        h_new = W'(hprod >>> FRAC);
    end
endmodule

// File: rtl/lstm_seq_engine.sv
// Serial LSTM layer engine: two MAC lanes (input x kernel, hidden x recurrent),
// a combining stage with bias, piecewise activations and a per-unit state update.
// Assumes HID, STEPS, FEAT >= 2 and arrays loaded while idle.
module lstm_seq_engine
    import lstm_pkg::*;
#(
    parameter int HID   = 8,
    parameter int STEPS = 64,
    parameter int FEAT  = 40,
    parameter int W     = 8,
    parameter int FRAC  = 4,
    parameter int AW    = 24,
    localparam int NG      = 4,
    localparam int XDEPTH  = STEPS * FEAT,
    localparam int KDEPTH  = NG * HID * FEAT,
    localparam int RDEPTH  = NG * HID * HID,
    localparam int BDEPTH  = NG * HID,
    localparam int ODEPTH  = STEPS * HID,
    localparam int LDEPTH  = (XDEPTH > KDEPTH) ? ((XDEPTH > RDEPTH) ? XDEPTH : RDEPTH)
                                               : ((KDEPTH > RDEPTH) ? KDEPTH : RDEPTH),
    localparam int LAW     = $clog2(LDEPTH),
    localparam int OAW     = $clog2(ODEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    output logic                 busy,
    output logic                 done,
    input  logic                 ld_en,
    input  logic [1:0]           ld_sel,
    input  logic [LAW-1:0]       ld_addr,
    input  logic signed [W-1:0]  ld_data,
    input  logic [OAW-1:0]       rd_addr,
    output logic signed [W-1:0]  rd_data
);
    localparam int KMAX = (FEAT > HID) ? FEAT : HID;
    localparam int KW   = $clog2(KMAX);
    localparam int UW   = $clog2(HID);
    localparam int TW   = $clog2(STEPS);
    localparam int XAW  = $clog2(XDEPTH);
    localparam int KAW  = $clog2(KDEPTH);
    localparam int RAW  = $clog2(RDEPTH);
    localparam int BAW  = $clog2(BDEPTH);
    localparam logic signed [AW:0] SAT_HI = (AW+1)'((1 << (W - 1)) - 1);
    localparam logic signed [AW:0] SAT_LO = (AW+1)'(-(1 << (W - 1)));

    logic signed [W-1:0] x_mem  [XDEPTH];
    logic signed [W-1:0] kw_mem [KDEPTH];
    logic signed [W-1:0] rw_mem [RDEPTH];
    logic signed [W-1:0] b_mem  [BDEPTH];
    logic signed [W-1:0] o_mem  [ODEPTH];
    logic signed [W-1:0] c_mem  [HID];
    logic signed [W-1:0] h_prev [HID];
    logic signed [W-1:0] h_cur  [HID];
    logic signed [W-1:0] gate_q [NG];

    state_e          state_q;
    gate_e           g_q;
    logic [TW-1:0]   t_q;
    logic [UW-1:0]   u_q;
    logic [KW-1:0]   k_q;
    logic            done_q;

    logic start_fire, upd_fire, last_k, last_u, last_t, last_g, x_ok, h_ok;
    logic [XAW-1:0]  x_a;
    logic [KAW-1:0]  k_a;
    logic [RAW-1:0]  r_a;
    logic [BAW-1:0]  b_a;
    logic [OAW-1:0]  o_a;
    logic signed [W-1:0]  x_op, kw_op, h_op, rw_op, z_sum, z_sig, z_tnh, c_new, h_new;
    logic signed [AW-1:0] acc_x, acc_h;
    logic signed [AW:0]   total, shifted;

    // control decodes
    assign start_fire = (state_q == S_IDLE) && start;
    assign upd_fire   = (state_q == S_UPD);
    assign last_k     = (k_q == KW'(KMAX - 1));
    assign last_u     = (u_q == UW'(HID - 1));
    assign last_t     = (t_q == TW'(STEPS - 1));
    assign last_g     = (g_q == G_OUT);
    assign x_ok       = int'(k_q) < FEAT;
    assign h_ok       = int'(k_q) < HID;
    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;

    // address generation for the current gate row
    always_comb begin
        int kx, kh, row;
        kx  = x_ok ? int'(k_q) : 0;
        kh  = h_ok ? int'(k_q) : 0;
        row = int'(g_q) * HID + int'(u_q);
        x_a = XAW'(int'(t_q) * FEAT + kx);
        k_a = KAW'(row * FEAT + kx);
        r_a = RAW'(row * HID + kh);
        b_a = BAW'(row);
        o_a = OAW'(int'(t_q) * HID + int'(u_q));
    end

    // operand fetch, zeroed outside each lane's length
    assign x_op  = x_ok ? x_mem[x_a]  : '0;
    assign kw_op = x_ok ? kw_mem[k_a] : '0;
    assign h_op  = h_ok ? h_prev[k_q[UW-1:0]] : '0;
    assign rw_op = h_ok ? rw_mem[r_a] : '0;

    lstm_mac #(.PW(W), .AW(AW)) u_mac_x (
        .clk(clk), .rst_n(rst_n), .clr(state_q != S_ACC), .en(state_q == S_ACC && x_ok),
        .a(x_op), .b(kw_op), .acc(acc_x));

    lstm_mac #(.PW(W), .AW(AW)) u_mac_h (
        .clk(clk), .rst_n(rst_n), .clr(state_q != S_ACC), .en(state_q == S_ACC && h_ok),
        .a(h_op), .b(rw_op), .acc(acc_h));

    // merge lanes with bias and requantize to W bits
    always_comb begin
        total   = (AW+1)'(acc_x) + (AW+1)'(acc_h) + ((AW+1)'(b_mem[b_a]) <<< FRAC);
        shifted = total >>> FRAC;
        if (shifted > SAT_HI)       z_sum = W'(SAT_HI);
        else if (shifted < SAT_LO)  z_sum = W'(SAT_LO);
        else                        z_sum = W'(shifted);
    end

    lstm_act #(.W(W), .FRAC(FRAC), .IS_SIG(1'b1)) u_sig (.z(z_sum), .y(z_sig));
    lstm_act #(.W(W), .FRAC(FRAC), .IS_SIG(1'b0)) u_tnh (.z(z_sum), .y(z_tnh));

    lstm_cell_upd #(.W(W), .FRAC(FRAC)) u_upd (
        .i_g(gate_q[G_IN]), .f_g(gate_q[G_FORGET]), .g_g(gate_q[G_CAND]),
        .o_g(gate_q[G_OUT]), .c_old(c_mem[u_q]), .c_new(c_new), .h_new(h_new));

    // schedule: accumulate, combine, then update after the fourth gate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            g_q     <= G_IN;
            t_q     <= '0;
            u_q     <= '0;
            k_q     <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_ACC;
                    g_q <= G_IN; t_q <= '0; u_q <= '0; k_q <= '0;
                end
                S_ACC: begin
                    k_q <= k_q + 1'b1;
                    if (last_k) state_q <= S_SUM;
                end
                S_SUM: begin
                    k_q <= '0;
                    if (last_g) state_q <= S_UPD;
                    else begin
                        g_q     <= gate_e'(g_q + 2'd1);
                        state_q <= S_ACC;
                    end
                end
                S_UPD: begin
                    g_q <= G_IN;
                    u_q <= last_u ? '0 : u_q + 1'b1;
                    if (last_u) t_q <= t_q + 1'b1;
                    if (last_u && last_t) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        state_q <= S_ACC;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // capture the activated gate value
    always_ff @(posedge clk) begin
        if (state_q == S_SUM) gate_q[g_q] <= (g_q == G_CAND) ? z_tnh : z_sig;
    end

    // recurrent state: cleared per window, updated per unit, rolled per step
    always_ff @(posedge clk) begin
        if (start_fire) begin
            for (int j = 0; j < HID; j++) begin
                c_mem[j]  <= '0;
                h_prev[j] <= '0;
                h_cur[j]  <= '0;
            end
        end else if (upd_fire) begin
            c_mem[u_q] <= c_new;
            h_cur[u_q] <= h_new;
            if (last_u) begin
                for (int j = 0; j < HID; j++)
                    h_prev[j] <= (UW'(j) == u_q) ? h_new : h_cur[j];
            end
        end
    end

    // hidden output array
    always_ff @(posedge clk) begin
        if (upd_fire) o_mem[o_a] <= h_new;
    end
    assign rd_data = o_mem[rd_addr];

    // parameter and input arrays, writable only while idle
    always_ff @(posedge clk) begin
        if (ld_en && state_q == S_IDLE) begin
            case (ld_sel)
                2'd0: if (int'(ld_addr) < XDEPTH) x_mem[ld_addr[XAW-1:0]]  <= ld_data;
                2'd1: if (int'(ld_addr) < KDEPTH) kw_mem[ld_addr[KAW-1:0]] <= ld_data;
                2'd2: if (int'(ld_addr) < RDEPTH) rw_mem[ld_addr[RAW-1:0]] <= ld_data;
                default: if (int'(ld_addr) < BDEPTH) b_mem[ld_addr[BAW-1:0]] <= ld_data;
            endcase
        end
    end
endmodule

// File: rtl/lstm_seq_engine_chk.sv
// Protocol and range checks for the LSTM engine, bound onto the top module.
// Assumes the Q format of the engine (ONE = 1 << FRAC).
module lstm_seq_engine_chk #(
    parameter int W    = 8,
    parameter int FRAC = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic                upd_fire,
    input logic signed [W-1:0] h_val
);
    localparam logic signed [W-1:0] ONE_S = W'(1 << FRAC);

    // R8: done never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: an idle start makes the engine busy on the next cycle
    a_r10_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R10: busy only ends together with done
    a_r10_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: done is never seen while still busy
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: every hidden value written lies within [-ONE, ONE]
    a_r5_h_range: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |-> (h_val >= -ONE_S && h_val <= ONE_S));

    // R9: a start while busy does not end the window on its own
    a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !upd_fire) |=> busy);
endmodule

bind lstm_seq_engine lstm_seq_engine_chk #(.W(W), .FRAC(FRAC)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .upd_fire(upd_fire), .h_val(h_new));

// File: tb/lstm_seq_engine_tb_top.sv
// Bench: small configuration, many weight/input patterns, arithmetic reference model.
module lstm_seq_engine_tb_top;
    localparam int H = 2, T = 3, F = 3, W = 8, ONE = 16;
    localparam int KMAX = (F > H) ? F : H;
    localparam int NCYC = T * H * (4 * (KMAX + 1) + 1);
    localparam int LAW = 5, OAW = 3;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ld_en = 1'b0;
    logic [1:0] ld_sel = '0;
    logic [LAW-1:0] ld_addr = '0;
    logic signed [W-1:0] ld_data = '0;
    logic [OAW-1:0] rd_addr = '0;
    logic busy, done;
    logic signed [W-1:0] rd_data;

    int nchk = 0, nerr = 0;
    bit finished = 1'b0;
    int unsigned seed = 32'h1234_5678;
    int xv[T*F]; int kv[4*H*F]; int rv[4*H*H]; int bv[4*H]; int expv[T*H];

    always #4 clk = ~clk;

    lstm_seq_engine #(.HID(H), .STEPS(T), .FEAT(F)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sat8(input int v);
        return (v > 127) ? 127 : ((v < -128) ? -128 : v);
    endfunction
    function automatic int hsig(input int z);
        if (z < -40) return 0;
        if (z > 40) return ONE;
        return ((13 * z + 32) >>> 6) + 8;
    endfunction
    function automatic int htanh(input int z);
        return (z < -ONE) ? -ONE : ((z > ONE) ? ONE : z);
    endfunction
    function automatic int rnd(input int mode);
        int v;
        seed = seed * 32'd1103515245 + 32'd12345;
        v = int'((seed >> 16) & 32'hFF);
        if (mode == 0) return (v % 7) - 3;
        if (mode == 1) return (v % 41) - 20;
        return v - 128;
    endfunction

    // reference: R2 sums, R3/R4 activations, R5 update, R6 zero start, R7 layout
    task automatic model();
        int c[H]; int hp[H]; int hn[H]; int gv[4];
        for (int j = 0; j < H; j++) begin c[j] = 0; hp[j] = 0; hn[j] = 0; end
        for (int t = 0; t < T; t++) begin
            for (int u = 0; u < H; u++) begin
                for (int g = 0; g < 4; g++) begin
                    int z = 0;
                    for (int k = 0; k < F; k++) z += xv[t*F+k] * kv[(g*H+u)*F+k];
                    for (int j = 0; j < H; j++) z += hp[j] * rv[(g*H+u)*H+j];
                    z += bv[g*H+u] * ONE;
                    z = sat8(z >>> 4);
                    gv[g] = (g == 2) ? htanh(z) : hsig(z);
                end
                c[u] = sat8((gv[1] * c[u] + gv[0] * gv[2]) >>> 4);
                hn[u] = (gv[3] * htanh(c[u])) >>> 4;
                expv[t*H+u] = hn[u];
            end
            for (int j = 0; j < H; j++) hp[j] = hn[j];
        end
    endtask

    task automatic ld1(input int sel, input int addr, input int val);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = 2'(sel); ld_addr = LAW'(addr); ld_data = W'(val);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // R11: fill all arrays through the load port
    task automatic load_all(input int mode);
        for (int i = 0; i < T*F; i++) begin xv[i] = rnd(mode); ld1(0, i, xv[i]); end
        for (int i = 0; i < 4*H*F; i++) begin kv[i] = rnd(mode); ld1(1, i, kv[i]); end
        for (int i = 0; i < 4*H*H; i++) begin rv[i] = rnd(mode); ld1(2, i, rv[i]); end
        for (int i = 0; i < 4*H; i++) begin bv[i] = rnd(mode); ld1(3, i, bv[i]); end
    endtask

    task automatic run_window(input bit disturb);
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        for (int c = 0; c < NCYC - 1; c++) begin
            @(posedge clk);
            if (c == 5) begin #1 chk("R10 busy during window", int'(busy), 1); end
            if (disturb && c == 10) begin
                #1 start = 1'b1; ld_en = 1'b1; ld_sel = 2'd1; ld_addr = '0; ld_data = 8'sh7f;
            end
            if (disturb && c == 11) begin #1 start = 1'b0; ld_en = 1'b0; end
        end
        @(negedge clk); chk("R8 done not early", int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 done on predicted edge", int'(done), 1);
        chk("R10 busy falls with done", int'(busy), 0);
        @(posedge clk);
        @(negedge clk); chk("R8 done one cycle", int'(done), 0);
        for (int i = 0; i < T*H; i++) begin
            rd_addr = OAW'(i);
            #1 chk(disturb ? "R9 R2 R3 R4 R5 R7 output under disturbance"
                           : "R2 R3 R4 R5 R6 R7 hidden output", int'(rd_data), expv[i]);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 done after reset", int'(done), 0);
        rst_n = 1'b1;
        for (int r = 0; r < 24; r++) begin
            if (r % 4 != 3) load_all(r % 3);   // r%4==3 reruns same data: R6
            model();
            run_window(r % 5 == 2);
        end
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule